// File: doc/BRIEF.md
# Concurrent Auto-Precharge Bank Tracker

This block follows the command stream of a four-bank synchronous DRAM and keeps the state of every bank: idle, open, running a burst that closes itself, or precharging. The device can accept a new read or write to one bank while another bank is still running a burst with auto precharge. When that happens, the running burst is cut short and its bank starts precharging on the edge that registers the new command. It does not wait for the burst's natural end.

The tracker sees each command on the clock edge that registers it. A command is an opcode, a bank number and an auto-precharge flag, together with the current level of the output-mask pin. It reports which banks are idle and which are precharging. It gives the read/write data path a one-cycle burst-terminate strobe, timed by the kind of interrupting command. It also raises one-cycle pulses for commands that are not legal in the target bank's state, and for a write that interrupts a read without the data mask set early enough.

Top module: `captrk_tracker`

## Requirements
- R1: While reset is held and in the cycle after it, every bank reports idle, none reports precharging, and `burstTerm`, `illegalCmd` and `maskViolation` are low.
- R2: Opcodes are NOP=0, ACTIVATE=1, READ=2, WRITE=3, PRECHARGE=4. An ACTIVATE (1) to an idle bank clears that bank's idle flag after the registering edge. An ACTIVATE to a bank that is not idle raises `illegalCmd` for exactly the cycle after that edge.
- R3: A READ (2), WRITE (3) or PRECHARGE (4) to a bank that is not open raises `illegalCmd` for the following cycle. It has no other effect: no bank changes state and no running burst is cut or terminated.
- R4: A READ or WRITE with `autoPre`=1 to an open bank, when no other access follows, sets that bank's precharging flag in the cycle after the edge that lies BURST_LEN edges after the registering edge. It gives no `burstTerm`.
- R5: A precharge lasts TRP_CYCLES cycles. The precharging flag then drops and the idle flag rises in the same cycle.
- R6: A READ to open bank m while bank n runs an auto-precharge burst sets bank n's precharging flag after the very edge that registers the READ.
- R7: In the case of R6, `burstTerm` is high for exactly the one cycle after the edge that lies CAS_LAT edges after the READ's registering edge.
- R8: A WRITE to open bank m while bank n runs an auto-precharge burst sets bank n precharging, and raises `burstTerm` for exactly one cycle, both after the edge that registers the WRITE.
- R9: When a WRITE interrupts an auto-precharge READ burst and `dqMask` was low on the edge two edges before the WRITE's edge, `maskViolation` is high for the cycle after the WRITE's edge. When `dqMask` was high on that edge, no violation is reported.
- R10: A READ or WRITE with `autoPre`=0 to bank m leaves bank m open but still interrupts the burst on bank n. A PRECHARGE (4) to an open bank starts its precharge after the registering edge.
- R11: No bank ever reports idle and precharging at the same time.
- R12: An interrupting access on the same edge where bank n's burst would have ended starts a single precharge from that edge, lasting TRP_CYCLES cycles, and still gives `burstTerm`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; commands are registered on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmd | input | 3 | Opcode of the registered command |
| cmdBank | input | BANK_W | Target bank of the command |
| autoPre | input | 1 | Auto-precharge flag for READ and WRITE |
| dqMask | input | 1 | Level of the output-mask pin |
| bankIdle | output | NUM_BANKS | One bit per bank, high while the bank is idle |
| bankPrecharging | output | NUM_BANKS | One bit per bank, high while the bank is precharging |
| burstTerm | output | 1 | One-cycle strobe telling the data path to stop the running burst |
| illegalCmd | output | 1 | One-cycle pulse for a command illegal in its bank's state |
| maskViolation | output | 1 | One-cycle pulse for an interrupting write without an early mask |

## Verification
Two things can land on bank n in the same cycle: its burst counter expires, and another bank's access interrupts it. Both call for the start of a precharge. The bench provokes this by placing a WRITE to another bank exactly BURST_LEN edges after an auto-precharge READ. It then checks that the precharge flag rises on that edge and not earlier, and that idle returns TRP_CYCLES cycles later, with no doubled or restarted precharge. It also checks that the terminate strobe still fires. A second overlap, an illegal access arriving while a burst runs, is checked to leave the burst's natural end intact.

// File: rtl/captrk_pkg.sv
package captrk_pkg;

  // command opcodes as seen on the registered command bus
  localparam logic [2:0] OP_NOP   = 3'd0;
  localparam logic [2:0] OP_ACT   = 3'd1;
  localparam logic [2:0] OP_READ  = 3'd2;
  localparam logic [2:0] OP_WRITE = 3'd3;
  localparam logic [2:0] OP_PRE   = 3'd4;

  typedef enum logic [1:0] {
    BK_IDLE   = 2'd0,
    BK_ACTIVE = 2'd1,
    BK_BURST  = 2'd2,
    BK_PRECH  = 2'd3
  } bank_state_e;

  // strobes from control to datapath for burst termination
  typedef struct packed {
    logic termRead;
    logic termWrite;
  } term_strobe_t;

endpackage

// File: rtl/captrk_datapath.sv
module captrk_datapath
  import captrk_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BURST_LEN  = 4,
  parameter int CAS_LAT    = 2,
  parameter int TRP_CYCLES = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 dqMask,
  input  logic [NUM_BANKS-1:0] loadBurst,
  input  logic [NUM_BANKS-1:0] loadPre,
  input  term_strobe_t         termStrobes,
  output logic [NUM_BANKS-1:0] cntZero,
  output logic                 dqmTwoAgo,
  output logic                 burstTerm
);

  localparam int CNT_MAX = (BURST_LEN > TRP_CYCLES) ? BURST_LEN : TRP_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  // one down-counter per bank, shared by the burst and precharge phases
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cnt
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (loadBurst[b]) begin
        cnt <= CNT_W'(BURST_LEN - 1);
      end else if (loadPre[b]) begin
        cnt <= CNT_W'(TRP_CYCLES - 1);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign cntZero[b] = (cnt == '0);
  end

  // read interrupts reach the data path CAS_LAT edges later than write ones
  logic [CAS_LAT:0] readTermPipe;
  logic             writeTermQ;
  logic [1:0]       dqmHist;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readTermPipe <= '0;
      writeTermQ   <= 1'b0;
      dqmHist      <= '0;
    end else begin
      readTermPipe <= {readTermPipe[CAS_LAT-1:0], termStrobes.termRead};
      writeTermQ   <= termStrobes.termWrite;
      dqmHist      <= {dqmHist[0], dqMask};
    end
  end

  assign burstTerm = writeTermQ | readTermPipe[CAS_LAT];
  assign dqmTwoAgo = dqmHist[1];

endmodule

// File: rtl/captrk_control.sv
module captrk_control
  import captrk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cmd,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 autoPre,
  input  logic [NUM_BANKS-1:0] cntZero,
  input  logic                 dqmTwoAgo,
  output logic [NUM_BANKS-1:0] loadBurst,
  output logic [NUM_BANKS-1:0] loadPre,
  output term_strobe_t         termStrobes,
  output logic [NUM_BANKS-1:0] bankIdle,
  output logic [NUM_BANKS-1:0] bankPrecharging,
  output logic                 illegalCmd,
  output logic                 maskViolation
);

  logic [NUM_BANKS-1:0] bankSel;
  logic [NUM_BANKS-1:0] isActive;
  logic [NUM_BANKS-1:0] inBurst;
  logic [NUM_BANKS-1:0] burstRead;
  logic [NUM_BANKS-1:0] interruptMask;
  logic isAccess, tgtIdle, tgtActive;
  logic accessOk, actOk, preOk, badCmd, interruptAny, readVictim;

  assign bankSel   = NUM_BANKS'(1) << cmdBank;
  assign isAccess  = (cmd == OP_READ) || (cmd == OP_WRITE);
  assign tgtIdle   = |(bankIdle & bankSel);
  assign tgtActive = |(isActive & bankSel);

  assign accessOk = isAccess && tgtActive;
  assign actOk    = (cmd == OP_ACT) && tgtIdle;
  assign preOk    = (cmd == OP_PRE) && tgtActive;
  assign badCmd   = (isAccess && !tgtActive)
                 || ((cmd == OP_ACT) && !tgtIdle)
                 || ((cmd == OP_PRE) && !tgtActive);

  // a legal access to another bank cuts any running self-closing burst
  assign interruptMask = accessOk ? (inBurst & ~bankSel) : '0;
  assign interruptAny  = |interruptMask;
  assign readVictim    = |(interruptMask & burstRead);

  assign termStrobes.termRead  = interruptAny && (cmd == OP_READ);
  assign termStrobes.termWrite = interruptAny && (cmd == OP_WRITE);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    bank_state_e cur;
    bank_state_e nxt;
    logic        ldBurst;
    logic        ldPre;
    logic        rdQ;

    always_comb begin
      nxt     = cur;
      ldBurst = 1'b0;
      ldPre   = 1'b0;
      unique case (cur)
        BK_IDLE: begin
          if (actOk && bankSel[b]) nxt = BK_ACTIVE;
        end
        BK_ACTIVE: begin
          if (accessOk && bankSel[b] && autoPre) begin
            nxt     = BK_BURST;
            ldBurst = 1'b1;
          end else if (preOk && bankSel[b]) begin
            nxt   = BK_PRECH;
            ldPre = 1'b1;
          end
        end
        BK_BURST: begin
          if (interruptMask[b] || cntZero[b]) begin
            nxt   = BK_PRECH;
            ldPre = 1'b1;
          end
        end
        BK_PRECH: begin
          if (cntZero[b]) nxt = BK_IDLE;
        end
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cur <= BK_IDLE;
        rdQ <= 1'b0;
      end else begin
        cur <= nxt;
        if (ldBurst) rdQ <= (cmd == OP_READ);
      end
    end

    assign loadBurst[b]       = ldBurst;
    assign loadPre[b]         = ldPre;
    assign burstRead[b]       = rdQ;
    assign isActive[b]        = (cur == BK_ACTIVE);
    assign inBurst[b]         = (cur == BK_BURST);
    assign bankIdle[b]        = (cur == BK_IDLE);
    assign bankPrecharging[b] = (cur == BK_PRECH);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      illegalCmd    <= 1'b0;
      maskViolation <= 1'b0;
    end else begin
      illegalCmd    <= badCmd;
      maskViolation <= termStrobes.termWrite && readVictim && !dqmTwoAgo;
    end
  end

endmodule

// File: rtl/captrk_tracker.sv
module captrk_tracker
  import captrk_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK_W     = $clog2(NUM_BANKS),
  parameter int BURST_LEN  = 4,
  parameter int CAS_LAT    = 2,
  parameter int TRP_CYCLES = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           cmd,
  input  logic [BANK_W-1:0]    cmdBank,
  input  logic                 autoPre,
  input  logic                 dqMask,
  output logic [NUM_BANKS-1:0] bankIdle,
  output logic [NUM_BANKS-1:0] bankPrecharging,
  output logic                 burstTerm,
  output logic                 illegalCmd,
  output logic                 maskViolation
);

  logic [NUM_BANKS-1:0] loadBurst;
  logic [NUM_BANKS-1:0] loadPre;
  logic [NUM_BANKS-1:0] cntZero;
  logic                 dqmTwoAgo;
  term_strobe_t         termStrobes;

  captrk_control #(
    .NUM_BANKS(NUM_BANKS),
    .BANK_W   (BANK_W)
  ) u_ctrl (
    .clk            (clk),
    .rstN           (rstN),
    .cmd            (cmd),
    .cmdBank        (cmdBank),
    .autoPre        (autoPre),
    .cntZero        (cntZero),
    .dqmTwoAgo      (dqmTwoAgo),
    .loadBurst      (loadBurst),
    .loadPre        (loadPre),
    .termStrobes    (termStrobes),
    .bankIdle       (bankIdle),
    .bankPrecharging(bankPrecharging),
    .illegalCmd     (illegalCmd),
    .maskViolation  (maskViolation)
  );

  captrk_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .BURST_LEN (BURST_LEN),
    .CAS_LAT   (CAS_LAT),
    .TRP_CYCLES(TRP_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .dqMask     (dqMask),
    .loadBurst  (loadBurst),
    .loadPre    (loadPre),
    .termStrobes(termStrobes),
    .cntZero    (cntZero),
    .dqmTwoAgo  (dqmTwoAgo),
    .burstTerm  (burstTerm)
  );

endmodule

// File: rtl/captrk_tracker_chk.sv
module captrk_tracker_chk
  import captrk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [2:0]           cmd,
  input logic [BANK_W-1:0]    cmdBank,
  input logic [NUM_BANKS-1:0] bankIdle,
  input logic [NUM_BANKS-1:0] bankPrecharging,
  input logic                 burstTerm,
  input logic                 illegalCmd,
  input logic                 maskViolation,
  input logic                 termWrite
);

  assert_exclusive_flags_R11: assert property (@(posedge clk) disable iff (!rstN)
    (bankIdle & bankPrecharging) == '0);

  assert_act_busy_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == OP_ACT) && !bankIdle[cmdBank] |=> illegalCmd);

  assert_act_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == OP_ACT) && bankIdle[cmdBank] |=> !illegalCmd && !bankIdle[$past(cmdBank)]);

  assert_access_closed_R3: assert property (@(posedge clk) disable iff (!rstN)
    ((cmd == OP_READ) || (cmd == OP_WRITE)) &&
    (bankIdle[cmdBank] || bankPrecharging[cmdBank]) |=> illegalCmd);

  assert_write_term_R8: assert property (@(posedge clk) disable iff (!rstN)
    termWrite |=> burstTerm);

  assert_violation_term_R9: assert property (@(posedge clk) disable iff (!rstN)
    maskViolation |-> burstTerm);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank_chk
    assert_pre_to_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(bankPrecharging[b]) |-> bankIdle[b]);
  end

endmodule

bind captrk_tracker captrk_tracker_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W)
) u_chk (
  .clk            (clk),
  .rstN           (rstN),
  .cmd            (cmd),
  .cmdBank        (cmdBank),
  .bankIdle       (bankIdle),
  .bankPrecharging(bankPrecharging),
  .burstTerm      (burstTerm),
  .illegalCmd     (illegalCmd),
  .maskViolation  (maskViolation),
  .termWrite      (termStrobes.termWrite)
);

// File: tb/tb_captrk_tracker.sv
module tb_captrk_tracker;
  import captrk_pkg::*;

  localparam int NB  = 4;
  localparam int BW  = 2;
  localparam int BL  = 4;
  localparam int CL  = 2;
  localparam int TRP = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [2:0]    cmd = OP_NOP;
  logic [BW-1:0] cmdBank = '0;
  logic          autoPre = 1'b0;
  logic          dqMask = 1'b0;
  logic [NB-1:0] bankIdle;
  logic [NB-1:0] bankPrecharging;
  logic          burstTerm;
  logic          illegalCmd;
  logic          maskViolation;

  always #4 clk = ~clk;

  captrk_tracker #(
    .NUM_BANKS(NB), .BANK_W(BW), .BURST_LEN(BL), .CAS_LAT(CL), .TRP_CYCLES(TRP)
  ) dut (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cmdBank(cmdBank), .autoPre(autoPre),
    .dqMask(dqMask), .bankIdle(bankIdle), .bankPrecharging(bankPrecharging),
    .burstTerm(burstTerm), .illegalCmd(illegalCmd), .maskViolation(maskViolation)
  );

  int cycCnt = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always @(posedge clk) if (rstN) cycCnt <= cycCnt + 1;

  typedef enum {SIG_IDLE, SIG_PRE, SIG_TERM, SIG_ILL, SIG_VIOL} sig_e;
  typedef struct {
    int            cyc;
    sig_e          sig;
    logic [NB-1:0] val;
    string         req;
  } item_t;

  item_t         expQ[$];
  logic [NB-1:0] actual;

  function automatic logic [NB-1:0] pick(sig_e s);
    case (s)
      SIG_IDLE: return bankIdle;
      SIG_PRE:  return bankPrecharging;
      SIG_TERM: return NB'(burstTerm);
      SIG_ILL:  return NB'(illegalCmd);
      default:  return NB'(maskViolation);
    endcase
  endfunction

  task automatic expectAt(int cyc, sig_e sig, logic [NB-1:0] val, string req);
    expQ.push_back('{cyc, sig, val, req});
  endtask

  task automatic checkNow(sig_e sig, logic [NB-1:0] val, string req);
    logic [NB-1:0] got;
    got = pick(sig);
    checks++;
    if (got !== val) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, sig.name(), got, val);
    end
  endtask

  // monitor: compare every queued item whose cycle has come
  always @(negedge clk) begin
    if (rstN) begin
      for (int i = expQ.size() - 1; i >= 0; i--) begin
        if (expQ[i].cyc == cycCnt) begin
          actual = pick(expQ[i].sig);
          checks++;
          if (actual !== expQ[i].val) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %b expected %b",
                     expQ[i].req, expQ[i].sig.name(), cycCnt, actual, expQ[i].val);
          end
          expQ.delete(i);
        end
      end
    end
  end

  // driver: called at a falling edge, holds the command for one rising edge
  task automatic drive(logic [2:0] c, int bnk, logic ap, logic dq);
    cmd     = c;
    cmdBank = BW'(bnk);
    autoPre = ap;
    dqMask  = dq;
    @(posedge clk);
    @(negedge clk);
    cmd     = OP_NOP;
    autoPre = 1'b0;
  endtask

  task automatic idleCycles(int n, logic dq);
    repeat (n) drive(OP_NOP, 0, 1'b0, dq);
  endtask

  function automatic int nextEdge();
    return cycCnt + 1;
  endfunction

  task automatic finishRun();
    foreach (expQ[i]) begin
      errors++;
      $display("FAIL %s %s: never compared, expected %b at cycle %0d",
               expQ[i].req, expQ[i].sig.name(), expQ[i].val, expQ[i].cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired before the sequence completed");
      finishRun();
    end
  end

  initial begin
    int k;
    int kw;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkNow(SIG_IDLE, 4'b1111, "R1");
    checkNow(SIG_PRE,  4'b0000, "R1");
    checkNow(SIG_TERM, 4'b0000, "R1");
    checkNow(SIG_ILL,  4'b0000, "R1");
    checkNow(SIG_VIOL, 4'b0000, "R1");
    rstN = 1'b1;
    expectAt(1, SIG_IDLE, 4'b1111, "R1");
    expectAt(1, SIG_TERM, 4'b0000, "R1");
    idleCycles(2, 1'b0);

    // R2: activate idle bank, then activate it again
    k = nextEdge();
    expectAt(k, SIG_IDLE, 4'b1110, "R2");
    expectAt(k, SIG_ILL,  4'b0000, "R2");
    drive(OP_ACT, 0, 1'b0, 1'b0);
    k = nextEdge();
    expectAt(k,     SIG_ILL, 4'b0001, "R2");
    expectAt(k + 1, SIG_ILL, 4'b0000, "R2");
    drive(OP_ACT, 0, 1'b0, 1'b0);
    idleCycles(2, 1'b0);

    // R3: read and precharge to closed banks are flagged and ignored
    k = nextEdge();
    expectAt(k, SIG_ILL,  4'b0001, "R3");
    expectAt(k, SIG_IDLE, 4'b1110, "R3");
    drive(OP_READ, 1, 1'b1, 1'b0);
    k = nextEdge();
    expectAt(k, SIG_ILL, 4'b0001, "R3");
    expectAt(k, SIG_PRE, 4'b0000, "R3");
    drive(OP_PRE, 2, 1'b0, 1'b0);
    idleCycles(2, 1'b0);

    // R4/R5/R11: uninterrupted auto-precharge read on bank 0
    k = nextEdge();
    expectAt(k + 2,       SIG_TERM, 4'b0000, "R4");
    expectAt(k + BL - 1,  SIG_PRE,  4'b0000, "R4");
    expectAt(k + BL,      SIG_PRE,  4'b0001, "R4");
    expectAt(k + BL + TRP - 1, SIG_PRE,  4'b0001, "R5");
    expectAt(k + BL + TRP - 1, SIG_IDLE, 4'b1110, "R11");
    expectAt(k + BL + TRP, SIG_PRE,  4'b0000, "R5");
    expectAt(k + BL + TRP, SIG_IDLE, 4'b1111, "R5");
    drive(OP_READ, 0, 1'b1, 1'b0);
    idleCycles(BL + TRP + 2, 1'b0);

    // R6/R7/R10: read without auto precharge to bank 1 interrupts bank 0
    drive(OP_ACT, 0, 1'b0, 1'b0);
    drive(OP_ACT, 1, 1'b0, 1'b0);
    drive(OP_READ, 0, 1'b1, 1'b0);
    k = nextEdge();
    expectAt(k - 1,      SIG_PRE,  4'b0000, "R6");
    expectAt(k,          SIG_PRE,  4'b0001, "R6");
    expectAt(k + CL - 1, SIG_TERM, 4'b0000, "R7");
    expectAt(k + CL,     SIG_TERM, 4'b0001, "R7");
    expectAt(k + CL + 1, SIG_TERM, 4'b0000, "R7");
    expectAt(k + TRP,    SIG_IDLE, 4'b1101, "R10");
    drive(OP_READ, 1, 1'b0, 1'b0);
    idleCycles(TRP + 2, 1'b0);
    k = nextEdge();
    expectAt(k,       SIG_PRE,  4'b0010, "R10");
    expectAt(k + TRP, SIG_IDLE, 4'b1111, "R10");
    drive(OP_PRE, 1, 1'b0, 1'b0);
    idleCycles(TRP + 2, 1'b0);

    // R8/R9: write interrupts read, mask low two edges before
    drive(OP_ACT, 0, 1'b0, 1'b0);
    drive(OP_ACT, 1, 1'b0, 1'b0);
    drive(OP_READ, 0, 1'b1, 1'b0);
    drive(OP_NOP, 0, 1'b0, 1'b0);
    kw = nextEdge();
    expectAt(kw,      SIG_PRE,  4'b0001, "R8");
    expectAt(kw,      SIG_TERM, 4'b0001, "R8");
    expectAt(kw + 1,  SIG_TERM, 4'b0000, "R8");
    expectAt(kw,      SIG_VIOL, 4'b0001, "R9");
    expectAt(kw + 1,  SIG_VIOL, 4'b0000, "R9");
    expectAt(kw + BL, SIG_PRE,  4'b0010, "R4");
    expectAt(kw + BL + TRP, SIG_IDLE, 4'b1111, "R5");
    drive(OP_WRITE, 1, 1'b1, 1'b0);
    idleCycles(BL + TRP + 2, 1'b0);

    // R9: mask raised early enough, no violation
    drive(OP_ACT, 0, 1'b0, 1'b0);
    drive(OP_ACT, 1, 1'b0, 1'b0);
    drive(OP_READ, 0, 1'b1, 1'b1);
    drive(OP_NOP, 0, 1'b0, 1'b1);
    kw = nextEdge();
    expectAt(kw, SIG_VIOL, 4'b0000, "R9");
    expectAt(kw, SIG_TERM, 4'b0001, "R8");
    drive(OP_WRITE, 1, 1'b0, 1'b0);
    idleCycles(TRP + 1, 1'b0);
    drive(OP_PRE, 1, 1'b0, 1'b0);
    idleCycles(TRP + 2, 1'b0);

    // R12: interrupt on the edge where the burst would have ended
    drive(OP_ACT, 0, 1'b0, 1'b1);
    drive(OP_ACT, 1, 1'b0, 1'b1);
    k = nextEdge();
    expectAt(k + BL - 1, SIG_PRE,  4'b0000, "R12");
    expectAt(k + BL,     SIG_PRE,  4'b0001, "R12");
    expectAt(k + BL,     SIG_TERM, 4'b0001, "R12");
    expectAt(k + BL,     SIG_VIOL, 4'b0000, "R12");
    expectAt(k + BL + TRP - 1, SIG_IDLE, 4'b1100, "R12");
    expectAt(k + BL + TRP,     SIG_IDLE, 4'b1101, "R12");
    drive(OP_READ, 0, 1'b1, 1'b1);
    idleCycles(BL - 1, 1'b1);
    drive(OP_WRITE, 1, 1'b0, 1'b1);
    idleCycles(TRP + 1, 1'b0);
    drive(OP_PRE, 1, 1'b0, 1'b0);
    idleCycles(TRP + 2, 1'b0);

    // R3: illegal access during a burst does not interrupt it
    drive(OP_ACT, 0, 1'b0, 1'b0);
    k = nextEdge();
    expectAt(k + 1,      SIG_ILL,  4'b0001, "R3");
    expectAt(k + 1,      SIG_PRE,  4'b0000, "R3");
    expectAt(k + 2,      SIG_TERM, 4'b0000, "R3");
    expectAt(k + 1 + CL, SIG_TERM, 4'b0000, "R3");
    expectAt(k + BL,     SIG_PRE,  4'b0001, "R3");
    drive(OP_READ, 0, 1'b1, 1'b0);
    drive(OP_READ, 2, 1'b0, 1'b0);
    idleCycles(BL + TRP + 2, 1'b0);

    done = 1'b1;
    finishRun();
  end

endmodule